// File: doc/BRIEF.md
# Down-Counting Timer Channel with Input Capture

This block is one channel of a timer. A counter of `W` bits counts down on a count enable. At zero it reloads from a reload register and sets an underflow status flag. The count enable is either a tick from an external prescaler or an edge of an external count pin. An optional interrupt reports the underflow flag.

A second pin drives the capture path. On the selected edge of this pin the channel can copy the running count into a capture register and set a capture status flag. The same edge raises a transfer request toward a DMA controller. The request stays high until that controller acknowledges it, and there is never more than one request outstanding.

Software writes the control register, the reload value, the count and the flags through simple write strobes.

Top module: `capture_timer`

## Requirements
- R1: After reset, the following are all 0: the count, the capture register, the reload register, the control register, both status flags, both interrupts and the DMA request.
- R2: Each count enable decrements the count by one. The one exception is an enable while the count is 0: the count then takes the reload register value and the underflow flag becomes 1. A count write (`cnt_we`) takes priority over counting.
- R3: `unf_irq` is 1 exactly when control bit 2 (underflow interrupt enable) is 1 and the underflow flag is 1.
- R4: Control bits [1:0] choose the active edge for both pins: 00 rising, 01 falling, 10 or 11 both. Each pin passes through two synchronizing flops and is compared against one more registered sample. As a result, a pin level first sampled at clock edge k acts at clock edge k+2.
- R5: On a capture event, the capture register loads the count present in that cycle, but only if the capture flag is 0. A capture event always sets the capture flag to 1. While the flag is 1, the capture register does not change.
- R6: Every capture event raises `dma_req` one cycle later, whatever the state of the capture flag. The request stays high until a cycle with `dma_ack` high, after which it is 0.
- R7: A capture event while `dma_req` is high does not add a request. After the acknowledge, `dma_req` stays 0 until a new capture event occurs.
- R8: Control bits [4:3] set the capture mode. Mode 00 and mode 01 disable capture: capture pin edges leave the capture register, the capture flag and `dma_req` unchanged. Modes 10 and 11 enable capture.
- R9: `cap_irq` is 1 exactly when the capture flag is 1 and the mode is 11. In mode 10 it stays 0.
- R10: A flag write (`flag_we`) clears the capture flag when bit 1 is 0 and the underflow flag when bit 0 is 0. A 1 in either bit has no effect. A hardware set in the same cycle as a clear wins.
- R11: When control bit 5 is 1, the count enable is the selected edge of `ext_cnt_pin` and `tick` is ignored. When control bit 5 is 0, `tick` is the count enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Internal count enable from the prescaler |
| ext_cnt_pin | input | 1 | External count pin (asynchronous) |
| cap_pin | input | 1 | Capture pin (asynchronous) |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | {count source, mode[1:0], underflow irq enable, edge select[1:0]} |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | W | Reload value |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | W | Count value |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | {capture flag, underflow flag}; a 0 clears the flag |
| dma_ack | input | 1 | Acknowledge from the DMA controller |
| count | output | W | Current count |
| capture | output | W | Capture register |
| unf_flag | output | 1 | Underflow status flag |
| cap_flag | output | 1 | Capture status flag |
| unf_irq | output | 1 | Underflow interrupt |
| cap_irq | output | 1 | Capture interrupt |
| dma_req | output | 1 | DMA transfer request |

## Verification
A pin change driven before clock edge k takes effect at edge k+2: the capture register, the capture flag and the count change then, and `dma_req` rises at the same edge. Register writes and acknowledges take effect at the next edge. The bench drives every input on the falling edge and waits a counted number of falling edges before it samples. For pin stimulus it allows four falling edges. The same-cycle set-and-clear case is timed exactly: the clear is placed two falling edges after the pin change, so that it lands on the edge where the capture happens. The count is frozen during capture tests, so the expected capture value is the value just written.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ext_cnt_pin,
  input  logic         cap_pin,
  input  logic         ctl_we,
  input  logic [5:0]   ctl_wdata,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         flag_we,
  input  logic [1:0]   flag_wdata,
  input  logic         dma_ack,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         unf_flag,
  output logic         cap_flag,
  output logic         unf_irq,
  output logic         cap_irq,
  output logic         dma_req
);

  logic [5:0]   ctl;
  logic [W-1:0] reload;
  logic [2:0]   cap_sh, ext_sh;

  wire       src_ext = ctl[5];
  wire [1:0] mode    = ctl[4:3];
  wire       unie    = ctl[2];
  wire [1:0] esel    = ctl[1:0];

  function automatic logic hit(input logic cur, input logic prv, input logic [1:0] sel);
    if (sel[1]) return cur ^ prv;
    if (sel[0]) return prv & ~cur;
    return cur & ~prv;
  endfunction

  wire cap_edge = hit(cap_sh[1], cap_sh[2], esel);
  wire ext_edge = hit(ext_sh[1], ext_sh[2], esel);
  wire cap_evt  = cap_edge & mode[1];
  wire dec_en   = src_ext ? ext_edge : tick;
  wire unf_evt  = dec_en & ~cnt_we & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sh <= '0;
      ext_sh <= '0;
    end else begin
      cap_sh <= {cap_sh[1:0], cap_pin};
      ext_sh <= {ext_sh[1:0], ext_cnt_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      reload <= '0;
    end else begin
      if (ctl_we)    ctl    <= ctl_wdata;
      if (reload_we) reload <= reload_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (cnt_we)  count <= cnt_wdata;
    else if (unf_evt) count <= reload;
    else if (dec_en)  count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unf_flag <= 1'b0;
      cap_flag <= 1'b0;
      capture  <= '0;
    end else begin
      if (unf_evt)                        unf_flag <= 1'b1;
      else if (flag_we && !flag_wdata[0]) unf_flag <= 1'b0;
      if (cap_evt)                        cap_flag <= 1'b1;
      else if (flag_we && !flag_wdata[1]) cap_flag <= 1'b0;
      if (cap_evt && !cap_flag)           capture  <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_req <= 1'b0;
    else if (dma_req) dma_req <= ~dma_ack;
    else              dma_req <= cap_evt;
  end

  assign unf_irq = unie & unf_flag;
  assign cap_irq = (mode == 2'b11) & cap_flag;

  a_r2_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !cnt_we && count == '0) |=> (count == $past(reload) && unf_flag));
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !cnt_we && count != '0) |=> (count == $past(count) - 1'b1));
  a_r3_unf_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    unf_irq |-> unf_flag);
  a_r5_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag |=> $stable(capture));
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> !dma_req);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !dma_req) |=> (!dma_req && $stable(capture)));
  a_r9_cap_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> cap_flag);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

endmodule

// File: tb/capture_timer_test.sv
module capture_timer_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, ext_cnt_pin = 0, cap_pin = 0;
  logic ctl_we = 0, reload_we = 0, cnt_we = 0, flag_we = 0, dma_ack = 0;
  logic [5:0] ctl_wdata = '0;
  logic [W-1:0] reload_wdata = '0, cnt_wdata = '0;
  logic [1:0] flag_wdata = '0;
  logic [W-1:0] count, capture;
  logic unf_flag, cap_flag, unf_irq, cap_irq, dma_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  capture_timer #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_cnt_pin(ext_cnt_pin),
    .cap_pin(cap_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .reload_we(reload_we), .reload_wdata(reload_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .dma_ack(dma_ack), .count(count), .capture(capture), .unf_flag(unf_flag),
    .cap_flag(cap_flag), .unf_irq(unf_irq), .cap_irq(cap_irq), .dma_req(dma_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1; ctl_wdata = v; step(1); ctl_we = 0;
  endtask

  task automatic wr_cnt(input logic [W-1:0] v);
    cnt_we = 1; cnt_wdata = v; step(1); cnt_we = 0;
  endtask

  task automatic wr_flag(input logic [1:0] v);
    flag_we = 1; flag_wdata = v; step(1); flag_we = 0;
  endtask

  task automatic ack();
    dma_ack = 1; step(1); dma_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 capture", capture, 0);
    chk("R1 flags", {unf_flag, cap_flag}, 0);
    chk("R1 irqs/dma", {unf_irq, cap_irq, dma_req}, 0);
  endtask

  task automatic t_count_wrap();
    reload_we = 1; reload_wdata = 16'd7; step(1); reload_we = 0;
    wr_cnt(16'd3);
    chk("R2 loaded", count, 3);
    tick = 1; step(1);
    chk("R2 decrement", count, 2);
    step(2);
    chk("R2 at zero", count, 0);
    chk("R2 no early flag", unf_flag, 0);
    step(1); tick = 0;
    chk("R2 reload on wrap", count, 7);
    chk("R2 underflow flag", unf_flag, 1);
  endtask

  task automatic t_unf_irq();
    chk("R3 irq masked", unf_irq, 0);
    wr_ctl(6'b000100);
    chk("R3 irq enabled", unf_irq, 1);
    wr_flag(2'b11);
    chk("R10 write 1 keeps unf flag", unf_flag, 1);
    wr_flag(2'b10);
    chk("R10 write 0 clears unf flag", unf_flag, 0);
    chk("R3 irq follows flag", unf_irq, 0);
    wr_ctl(6'b000000);
  endtask

  task automatic t_disabled(input logic [1:0] md);
    wr_ctl({1'b0, md, 3'b010});
    wr_cnt(16'h0bad);
    cap_pin = ~cap_pin; step(4);
    chk("R8 mode disables capture reg", capture, 0);
    chk("R8 mode disables flag", cap_flag, 0);
    chk("R8 mode disables dma", dma_req, 0);
  endtask

  task automatic t_capture_rise();
    cap_pin = 0; step(4);
    wr_ctl(6'b010000);
    wr_cnt(16'h1234);
    cap_pin = 1; step(4);
    chk("R5 capture on rise", capture, 16'h1234);
    chk("R5 capture flag set", cap_flag, 1);
    chk("R6 dma raised", dma_req, 1);
    chk("R9 mode 10 masks irq", cap_irq, 0);
    wr_ctl(6'b011000);
    chk("R9 mode 11 irq", cap_irq, 1);
    ack();
    chk("R6 ack clears req", dma_req, 0);
    wr_cnt(16'h5555);
    cap_pin = 0; step(4);
    chk("R4 falling edge ignored in rise mode", dma_req, 0);
    chk("R4 capture unchanged", capture, 16'h1234);
  endtask

  task automatic t_flag_blocks();
    wr_cnt(16'h2222);
    cap_pin = 1; step(4);
    chk("R5 flag set blocks capture", capture, 16'h1234);
    chk("R6 dma despite flag", dma_req, 1);
    wr_cnt(16'h3333);
    cap_pin = 0; step(1); cap_pin = 1; step(4);
    chk("R7 still one request", dma_req, 1);
    ack();
    step(3);
    chk("R7 no queued request", dma_req, 0);
  endtask

  task automatic t_set_wins();
    wr_cnt(16'h4444);
    cap_pin = 0; step(4);
    ack(); chk("R6 drain", dma_req, 0);
    cap_pin = 1; step(2);
    flag_we = 1; flag_wdata = 2'b01; step(1); flag_we = 0;
    chk("R10 set wins over clear", cap_flag, 1);
    chk("R5 no update while flag was 1", capture, 16'h1234);
    ack();
    wr_flag(2'b01);
    chk("R10 clear cap flag", cap_flag, 0);
    chk("R9 irq follows flag", cap_irq, 0);
  endtask

  task automatic t_edges();
    wr_ctl(6'b010001);
    wr_cnt(16'h00f0);
    cap_pin = 0; step(4);
    chk("R4 falling capture", capture, 16'h00f0);
    ack(); wr_flag(2'b01);
    wr_ctl(6'b010010);
    wr_cnt(16'h00a1);
    cap_pin = 1; step(4);
    chk("R4 both: rise captured", capture, 16'h00a1);
    ack(); wr_flag(2'b01);
    wr_cnt(16'h00a2);
    cap_pin = 0; step(4);
    chk("R4 both: fall captured", capture, 16'h00a2);
    ack(); wr_flag(2'b01);
  endtask

  task automatic t_ext_count();
    wr_ctl(6'b100001);
    wr_cnt(16'd10);
    tick = 1;
    ext_cnt_pin = 1; step(4);
    chk("R11 tick ignored, rise not selected", count, 10);
    ext_cnt_pin = 0; step(4);
    chk("R11 falling edge counts", count, 9);
    wr_ctl(6'b100011);
    ext_cnt_pin = 1; step(4);
    chk("R11 both edges counts rise", count, 8);
    tick = 0;
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1; step(1);
    t_reset();
    t_count_wrap();
    t_unf_irq();
    t_disabled(2'b00);
    t_disabled(2'b01);
    t_capture_rise();
    t_flag_blocks();
    t_set_wins();
    t_edges();
    t_ext_count();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule